// File: doc/BRIEF.md
# Predetermining BCD Up/Down Counter

A six-decade decimal counter that steps once per rising edge of an external count line, up or down, with full carry and borrow between decades. Three BCD registers sit beside it: a reload value, an early-warning value and a terminal value. Each of the last two, plus a test for zero, drives a flag output. The counter can be cleared or loaded by hand, and it acts on its own at its end points. Counting up into the terminal value clears it. Counting down into zero reloads it from the reload value. Each automatic action has its own disable input.

The three registers are written one decade at a time over a 4-bit bus. A 2-bit register select picks the target. A one-hot decade strobe picks which nibble captures the bus. Everything runs on one system clock. The count line is asynchronous and passes through a synchroniser and edge detector.

Top module: `bcd_predet_counter`

## Requirements
- R1: Each count step adds or subtracts one in decimal. Decade i is `count_val[4i+3:4i]`, and decade 0 is the least significant. Carries and borrows ripple through all six decades. 999999 plus one gives 000000, and 000000 minus one gives 999999.
- R2: `dir_up` high makes a step increment. `dir_up` low makes a step decrement.
- R3: While `count_hold` is high, count steps leave the count unchanged.
- R4: While `clear_req` is high, the count is forced to 000000 and stays there, whatever steps arrive.
- R5: A clock edge with `load_req` high copies the reload register into the count.
- R6: When counting up with `no_auto_clear` low and the count equal to the terminal register, the next clock clears the count to zero. With `no_auto_clear` high, counting continues past that value.
- R7: When counting down with `no_auto_reload` low and the count at zero, the next clock loads the reload register. With `no_auto_reload` high, the count wraps to 999999 on the next step.
- R8: The `store_sel` code selects the register that is written: 2'b00 selects none, 2'b01 the early-warning register, 2'b10 the terminal register, and 2'b11 the reload register.
- R9: `early_flag`, `term_flag` and `zero_flag` are registered. One clock after the count equals the early-warning register, the terminal register or zero, the matching flag is high. Otherwise it is low.
- R10: On a clock edge with a non-zero select, strobe bit i writes `data_nib` into decade i of the selected register. Decades whose strobe bit is low keep their value.
- R11: The count obeys this priority: clear, then manual load, then automatic clear or reload, then hold, then counting. Writing a register never changes the count by itself.
- R12: Each rising edge of `count_in` produces exactly one step. The step appears on `count_val` at the third clock edge after the first clock edge that samples `count_in` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_in | input | 1 | Asynchronous count line, active on rising edge |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| count_hold | input | 1 | Freezes counting while high |
| clear_req | input | 1 | Forces and holds the count at zero |
| load_req | input | 1 | Loads the reload register into the count |
| no_auto_clear | input | 1 | Disables the clear at the terminal value |
| no_auto_reload | input | 1 | Disables the reload at zero |
| data_nib | input | 4 | BCD digit to write |
| store_sel | input | 2 | Register select for writes |
| digit_stb | input | 6 | One-hot decade strobe for writes |
| count_val | output | 24 | Current count, six BCD decades |
| early_flag | output | 1 | Count equals the early-warning register |
| term_flag | output | 1 | Count equals the terminal register |
| zero_flag | output | 1 | Count is zero |

## Verification
The hardest cases to reach are the automatic end-point actions. In each, the count must sit exactly on a value held in a register while the matching disable input is low. After reset the terminal register holds zero, and in up mode this would clear the count on every clock. The bench therefore keeps both disable inputs high while it fills the registers and places the count with a manual load. It then rewrites the reload register to a different value before it enables the automatic action. This makes a reload from the register distinguishable from the value that was loaded by hand. Both the enabled and the inhibited form of each end point are then driven with single count pulses.

// File: rtl/bcd_predet_pkg.sv
// Package: shared constants and the register-select encoding for the
// predetermining BCD counter. Assumes 4-bit BCD decades.
package bcd_predet_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'b00,
        SEL_EARLY  = 2'b01,
        SEL_TERM   = 2'b10,
        SEL_RELOAD = 2'b11
    } store_sel_e;
endpackage

// File: rtl/cnt_edge_sync.sv
// Module: cnt_edge_sync
// Brings an asynchronous count line into the clock domain through a
// synchroniser chain. Emits a one-cycle pulse per rising edge.
// Assumes STAGES >= 2 and input pulses of at least two clocks high and low.
module cnt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw input through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bcd_store_bank.sv
// Module: bcd_store_bank
// Holds the early-warning, terminal and reload registers. Each is written
// one decade per clock: the select code picks the register and a one-hot
// strobe picks the decade. Assumes the bus carries valid BCD digits.
module bcd_store_bank
    import bcd_predet_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int W = NIB_W * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       store_sel,
    input  logic [NIB_W-1:0] data_nib,
    input  logic [DIGITS-1:0] digit_stb,
    output logic [W-1:0]     early_val,
    output logic [W-1:0]     term_val,
    output logic [W-1:0]     reload_val
);
    localparam int NREG = 3;

    logic [W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            // Capture the bus into this decade when selected and strobed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g][NIB_W*d +: NIB_W] <= '0;
                else if (store_sel == 2'(g + 1) && digit_stb[d])
                    regs_q[g][NIB_W*d +: NIB_W] <= data_nib;
            end
        end
    end

    assign early_val  = regs_q[int'(SEL_EARLY)  - 1];
    assign term_val   = regs_q[int'(SEL_TERM)   - 1];
    assign reload_val = regs_q[int'(SEL_RELOAD) - 1];
endmodule

// File: rtl/bcd_updown_core.sv
// Module: bcd_updown_core
// Six-decade (parameterised) BCD up/down counter with clear, manual load,
// automatic clear at the terminal value (up) and automatic reload at zero
// (down). Priority: clear, load, automatic action, hold, count step.
module bcd_updown_core
    import bcd_predet_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int W = NIB_W * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         dir_up,
    input  logic         count_hold,
    input  logic         clear_req,
    input  logic         load_req,
    input  logic         no_auto_clear,
    input  logic         no_auto_reload,
    input  logic [W-1:0] reload_val,
    input  logic [W-1:0] term_val,
    output logic [W-1:0] count_q
);
    logic [W-1:0]      up_val, dn_val;
    logic [DIGITS-1:0] cy, bw;
    logic              auto_up, auto_dn;

    assign cy[0] = 1'b1;
    assign bw[0] = 1'b1;

    for (genvar d = 0; d < DIGITS; d++) begin : g_dec
        logic [NIB_W-1:0] dig;
        assign dig = count_q[NIB_W*d +: NIB_W];
        assign up_val[NIB_W*d +: NIB_W] = !cy[d] ? dig : (dig == 4'd9) ? 4'd0 : dig + 4'd1;
        assign dn_val[NIB_W*d +: NIB_W] = !bw[d] ? dig : (dig == 4'd0) ? 4'd9 : dig - 4'd1;
        if (d < DIGITS - 1) begin : g_chain
            assign cy[d+1] = cy[d] & (dig == 4'd9);
            assign bw[d+1] = bw[d] & (dig == 4'd0);
        end
    end

    assign auto_up = dir_up & ~no_auto_clear & (count_q == term_val);
    assign auto_dn = ~dir_up & ~no_auto_reload & (count_q == '0);

    // Select the next count by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (clear_req)  count_q <= '0;
        else if (load_req)   count_q <= reload_val;
        else if (auto_up)    count_q <= '0;
        else if (auto_dn)    count_q <= reload_val;
        else if (count_hold) count_q <= count_q;
        else if (step)       count_q <= dir_up ? up_val : dn_val;
    end
endmodule

// File: rtl/bcd_match_flags.sv
// Module: bcd_match_flags
// Compares the count with the early-warning and terminal registers and
// with zero, and registers the results so the flags are glitch-free.
module bcd_match_flags
    import bcd_predet_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int W = NIB_W * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_q,
    input  logic [W-1:0] early_val,
    input  logic [W-1:0] term_val,
    output logic         early_flag,
    output logic         term_flag,
    output logic         zero_flag
);
    // Register the three equality results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_flag <= 1'b0;
            term_flag  <= 1'b0;
            zero_flag  <= 1'b0;
        end else begin
            early_flag <= (count_q == early_val);
            term_flag  <= (count_q == term_val);
            zero_flag  <= (count_q == '0);
        end
    end
endmodule

// File: rtl/bcd_predet_counter.sv
// Module: bcd_predet_counter
// Top level: the count synchroniser, the register bank, the counter core
// and the flag compare, wired together. Assumes count_in pulses last at
// least two clocks high and two clocks low.
module bcd_predet_counter
    import bcd_predet_pkg::*;
#(
    parameter int DIGITS      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int W = NIB_W * DIGITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_in,
    input  logic              dir_up,
    input  logic              count_hold,
    input  logic              clear_req,
    input  logic              load_req,
    input  logic              no_auto_clear,
    input  logic              no_auto_reload,
    input  logic [NIB_W-1:0]  data_nib,
    input  logic [1:0]        store_sel,
    input  logic [DIGITS-1:0] digit_stb,
    output logic [W-1:0]      count_val,
    output logic              early_flag,
    output logic              term_flag,
    output logic              zero_flag
);
    logic         step_pulse;
    logic [W-1:0] early_val, term_val, reload_val;

    cnt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (count_in),
        .rise_pulse (step_pulse)
    );

    bcd_store_bank #(.DIGITS(DIGITS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_sel  (store_sel),
        .data_nib   (data_nib),
        .digit_stb  (digit_stb),
        .early_val  (early_val),
        .term_val   (term_val),
        .reload_val (reload_val)
    );

    bcd_updown_core #(.DIGITS(DIGITS)) core_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .step           (step_pulse),
        .dir_up         (dir_up),
        .count_hold     (count_hold),
        .clear_req      (clear_req),
        .load_req       (load_req),
        .no_auto_clear  (no_auto_clear),
        .no_auto_reload (no_auto_reload),
        .reload_val     (reload_val),
        .term_val       (term_val),
        .count_q        (count_val)
    );

    bcd_match_flags #(.DIGITS(DIGITS)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_q    (count_val),
        .early_val  (early_val),
        .term_val   (term_val),
        .early_flag (early_flag),
        .term_flag  (term_flag),
        .zero_flag  (zero_flag)
    );
endmodule

// File: rtl/bcd_predet_checker.sv
// Module: bcd_predet_checker
// Temporal properties of the predetermining counter, bound to the top.
module bcd_predet_checker #(
    parameter int DIGITS = 6,
    localparam int W = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dir_up,
    input logic         count_hold,
    input logic         clear_req,
    input logic         load_req,
    input logic         no_auto_clear,
    input logic         no_auto_reload,
    input logic [W-1:0] count_val,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] term_val,
    input logic         zero_flag
);
    logic at_term_up, at_zero_dn;
    assign at_term_up = dir_up && !no_auto_clear && count_val == term_val;
    assign at_zero_dn = !dir_up && !no_auto_reload && count_val == '0;

    p_clear_holds_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> count_val == '0);

    p_manual_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req && load_req |=> count_val == $past(reload_val));

    p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req && !load_req && at_term_up |=> count_val == '0);

    p_auto_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req && !load_req && at_zero_dn |=> count_val == $past(reload_val));

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req && !load_req && count_hold && !at_term_up && !at_zero_dn
        |=> $stable(count_val));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> zero_flag == ($past(count_val) == '0));
endmodule

bind bcd_predet_counter bcd_predet_checker #(.DIGITS(DIGITS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_up         (dir_up),
    .count_hold     (count_hold),
    .clear_req      (clear_req),
    .load_req       (load_req),
    .no_auto_clear  (no_auto_clear),
    .no_auto_reload (no_auto_reload),
    .count_val      (count_val),
    .reload_val     (reload_val),
    .term_val       (term_val),
    .zero_flag      (zero_flag)
);

// File: tb/bcd_predet_counter_tb_top.sv
// Directed bench for bcd_predet_counter: one task per scenario.
module bcd_predet_counter_tb_top;
    localparam int DIGITS = 6;
    localparam int W = 4 * DIGITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic count_in = 1'b0;
    logic dir_up = 1'b1;
    logic count_hold = 1'b0;
    logic clear_req = 1'b0;
    logic load_req = 1'b0;
    logic no_auto_clear = 1'b1;
    logic no_auto_reload = 1'b1;
    logic [3:0] data_nib = '0;
    logic [1:0] store_sel = '0;
    logic [DIGITS-1:0] digit_stb = '0;
    logic [W-1:0] count_val;
    logic early_flag, term_flag, zero_flag;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    bcd_predet_counter dut_i (
        .clk(clk), .rst_n(rst_n), .count_in(count_in), .dir_up(dir_up),
        .count_hold(count_hold), .clear_req(clear_req), .load_req(load_req),
        .no_auto_clear(no_auto_clear), .no_auto_reload(no_auto_reload),
        .data_nib(data_nib), .store_sel(store_sel), .digit_stb(digit_stb),
        .count_val(count_val), .early_flag(early_flag), .term_flag(term_flag),
        .zero_flag(zero_flag)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_store(input logic [1:0] sel, input logic [W-1:0] val);
        for (int d = 0; d < DIGITS; d++) begin
            store_sel = sel;
            data_nib  = val[4*d +: 4];
            digit_stb = DIGITS'(1) << d;
            ticks(1);
        end
        store_sel = 2'b00;
        digit_stb = '0;
    endtask

    task automatic do_load();
        load_req = 1'b1;
        ticks(1);
        load_req = 1'b0;
        ticks(2);
    endtask

    task automatic pulse();
        count_in = 1'b1;
        ticks(2);
        count_in = 1'b0;
        ticks(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ticks(3);
        check("R4 count in reset", count_val, '0);
        rst_n = 1'b1;
        ticks(2);
        check("R9 zero flag after reset", W'(zero_flag), W'(1));
    endtask

    task automatic t_up_carry();
        write_store(2'b11, 24'h000998);
        check("R11 store write leaves count", count_val, '0);
        do_load();
        check("R5 manual load", count_val, 24'h000998);
        dir_up = 1'b1;
        pulse();
        check("R2 up step", count_val, 24'h000999);
        pulse();
        check("R1 carry across decades", count_val, 24'h001000);
        check("R9 zero flag low", W'(zero_flag), '0);
    endtask

    task automatic t_down_wrap();
        dir_up = 1'b0;
        pulse();
        check("R1 borrow across decades", count_val, 24'h000999);
        write_store(2'b11, 24'h999999);
        do_load();
        dir_up = 1'b1;
        pulse();
        check("R1 wrap up to zero", count_val, 24'h000000);
        dir_up = 1'b0;
        pulse();
        check("R7 inhibited reload wraps down", count_val, 24'h999999);
    endtask

    task automatic t_edge_latency();
        // R12: the step shows at the third clock edge after the first sample.
        write_store(2'b11, 24'h000040);
        do_load();
        dir_up = 1'b1;
        count_in = 1'b1;
        ticks(2);
        check("R12 no step before third edge", count_val, 24'h000040);
        ticks(1);
        check("R12 step at third edge", count_val, 24'h000041);
        ticks(3);
        check("R12 one step per long pulse", count_val, 24'h000041);
        count_in = 1'b0;
        ticks(3);
    endtask

    task automatic t_hold();
        count_hold = 1'b1;
        pulse();
        check("R3 hold freezes count", count_val, 24'h000041);
        count_hold = 1'b0;
        pulse();
        check("R3 release resumes counting", count_val, 24'h000042);
    endtask

    task automatic t_clear_priority();
        clear_req = 1'b1;
        load_req  = 1'b1;
        ticks(1);
        load_req = 1'b0;
        pulse();
        check("R4 clear held against steps", count_val, '0);
        check("R11 clear beats load", count_val, '0);
        clear_req = 1'b0;
        ticks(1);
        count_hold = 1'b1;
        do_load();
        check("R11 load beats hold", count_val, 24'h000040);
        count_hold = 1'b0;
    endtask

    task automatic t_auto_clear();
        write_store(2'b10, 24'h000005);
        write_store(2'b11, 24'h000004);
        do_load();
        dir_up = 1'b1;
        pulse();
        check("R9 term flag at terminal", W'(term_flag), W'(1));
        check("R6 inhibited clear holds terminal", count_val, 24'h000005);
        pulse();
        check("R6 inhibited clear counts past", count_val, 24'h000006);
        do_load();
        no_auto_clear = 1'b0;
        pulse();
        check("R6 automatic clear at terminal", count_val, '0);
        check("R9 term flag low after clear", W'(term_flag), '0);
        no_auto_clear = 1'b1;
    endtask

    task automatic t_auto_reload();
        write_store(2'b11, 24'h000001);
        do_load();
        write_store(2'b11, 24'h000007);
        check("R11 rewrite leaves count", count_val, 24'h000001);
        dir_up = 1'b0;
        no_auto_reload = 1'b0;
        pulse();
        check("R7 automatic reload at zero", count_val, 24'h000007);
        no_auto_reload = 1'b1;
        dir_up = 1'b1;
    endtask

    task automatic t_select_and_strobe();
        write_store(2'b00, 24'h123456);
        do_load();
        check("R8 select 00 writes nothing", count_val, 24'h000007);
        store_sel = 2'b11;
        data_nib  = 4'd3;
        digit_stb = 6'b000100;
        ticks(1);
        store_sel = 2'b00;
        digit_stb = '0;
        do_load();
        check("R10 strobe writes one decade", count_val, 24'h000307);
        write_store(2'b01, 24'h000308);
        dir_up = 1'b1;
        pulse();
        check("R8 early register selected by 01", W'(early_flag), W'(1));
        check("R9 term flag low off terminal", W'(term_flag), '0);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        ticks(1);
        t_reset();
        t_up_carry();
        t_down_wrap();
        t_edge_latency();
        t_hold();
        t_clear_priority();
        t_auto_clear();
        t_auto_reload();
        t_select_and_strobe();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule